// File: doc/BRIEF.md
# Segmented Thermometer-to-Gray Encoder

This block turns the 256-bit output of a comparator array into an 8-bit Gray-coded sample and a separate overrange flag. Bit 0 of the input belongs to the comparator with the lowest threshold. For a clean input, the bits from position 0 up to the crossing point are 1 and every bit above it is 0. The array is cut into four columns of 64 positions. Each column finds its own 1-to-0 transition and reports a 6-bit fine position. A column encoder then turns the number of the highest column with a transition into the two most significant bits.

Before the transition search, every bit is replaced by the majority of itself and its two neighbours. Below position 0 the bench of comparators acts as if there were a virtual 1, and above the top position a virtual 0. This smoothing removes a single flipped comparator, or pushes it into a one-level error at the crossing point.

The pipeline uses both clock edges:
- The raw vector is registered on the rising edge.
- The column decode is registered into 7-bit column latches on the falling edge.
- The Gray code and the overrange flag are registered on the next rising edge.

A sample therefore appears on the outputs one clock after it is captured. A new sample can be accepted on every clock.

Top module: `thermo_gray_enc`

## Requirements
- R1: A vector present at rising edge k is reflected on `gray_out`/`ovr_out` right after rising edge k+1, and a different vector can be accepted at every rising edge, with results emerging in input order.
- R2: A clean input of level L, meaning bits 0..L-1 set and the rest clear, with 0 <= L <= 255, gives `gray_out` = L ^ (L >> 1) and `ovr_out` = 0.
- R3: An input with all 256 bits set gives `ovr_out` = 1 and `gray_out` = 8'b1000_0000. `ovr_out` is 0 for every clean level below 256.
- R4: Fixed code points: L=0 gives 8'b0000_0000, L=127 gives 8'b0100_0000, L=128 gives 8'b1100_0000, and L=255 gives 8'b1000_0000 with `ovr_out` = 0.
- R5: A clean level L with any one bit inverted gives an output level within one of L. The output level is the binary value of `gray_out`, or 256 when `ovr_out` is 1.
- R6: An inverted bit at position j has no effect on the output when j <= L-3 or j >= L+2.
- R7: While `rst` is high at a rising edge, `gray_out` and `ovr_out` become 0 at that edge, whatever the input.
- R8: Levels on either side of a column boundary (63, 64, 65, 191, 192, 193) decode exactly, with the two MSBs naming the column that holds the transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; rising edge captures, falling edge latches the column decode |
| rst | input | 1 | Synchronous active-high reset |
| therm_in | input | 256 | Comparator vector, bit 0 = lowest threshold |
| gray_out | output | 8 | Registered Gray-coded sample |
| ovr_out | output | 1 | Registered overrange flag |

## Verification
The bubble correction and the overrange decision act in the same cycle when a flipped comparator lands within two positions of the top of the array. There the smoothed top bit decides both whether overrange is raised and where the last column finds its transition. The bench provokes this with directed levels 253 to 256, each with a single inverted bit at positions 252 to 255. It judges the result by treating overrange as a 257th level and requiring the combined value to stay within one of the clean level. Random single-bubble patterns across all levels cover the same rule elsewhere, and exact equality is demanded where the flipped bit lies far from the crossing point.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    parameter int unsigned TGC_NCOL   = 4;
    parameter int unsigned TGC_COL_W  = 64;

    localparam int unsigned TGC_NPOS   = TGC_NCOL * TGC_COL_W;
    localparam int unsigned TGC_IDX_W  = $clog2(TGC_COL_W);
    localparam int unsigned TGC_SEL_W  = $clog2(TGC_NCOL);
    localparam int unsigned TGC_CODE_W = TGC_IDX_W + TGC_SEL_W;

    typedef logic [TGC_IDX_W-1:0]  fine_t;
    typedef logic [TGC_SEL_W-1:0]  sel_t;
    typedef logic [TGC_CODE_W-1:0] code_t;

    // One column latch: transition seen, and its position inside the column
    typedef struct packed {
        logic  hit;
        fine_t idx;
    } col_res_t;

    typedef struct packed {
        logic  ovr;
        code_t code;
    } sample_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic code_t bin_to_gray(input code_t b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/tgc_bubble_filter.sv
module tgc_bubble_filter
    import tgc_pkg::*;
#(
    parameter int unsigned N = TGC_NPOS
) (
    input  logic [N-1:0] raw,
    output logic [N-1:0] clean
);

    // Virtual 1 below the lowest comparator, virtual 0 above the highest
    logic [N+1:0] ext;
    assign ext = {1'b0, raw, 1'b1};

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign clean[i] = maj3(ext[i], ext[i+1], ext[i+2]);
    end

endmodule

// File: rtl/tgc_column_dec.sv
module tgc_column_dec
    import tgc_pkg::*;
#(
    parameter int unsigned COL_W = TGC_COL_W
) (
    input  logic [COL_W-1:0] seg,
    input  logic             below,
    output col_res_t         res
);

    logic [COL_W:0]   ext;
    logic [COL_W-1:0] edge_v;

    assign ext = {seg, below};

    // Level j inside the column: position j-1 set, position j clear
    for (genvar j = 0; j < COL_W; j++) begin : g_edge
        assign edge_v[j] = ext[j] & ~ext[j+1];
    end

    // Highest transition wins
    always_comb begin
        res = '0;
        for (int j = 0; j < COL_W; j++) begin
            if (edge_v[j]) begin
                res.hit = 1'b1;
                res.idx = fine_t'(j);
            end
        end
    end

endmodule

// File: rtl/tgc_msb_enc.sv
module tgc_msb_enc
    import tgc_pkg::*;
#(
    parameter int unsigned NCOL = TGC_NCOL
) (
    input  col_res_t [NCOL-1:0] cols,
    input  logic                ovr,
    output code_t               level
);

    always_comb begin
        level = '0;
        for (int c = 0; c < NCOL; c++) begin
            if (cols[c].hit) begin
                level = {sel_t'(c), cols[c].idx};
            end
        end
        if (ovr) begin
            level = '1;
        end
    end

endmodule

// File: rtl/thermo_gray_enc.sv
module thermo_gray_enc
    import tgc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TGC_NPOS-1:0]   therm_in,
    output logic [TGC_CODE_W-1:0] gray_out,
    output logic                  ovr_out
);

    localparam int unsigned NCOL  = TGC_NCOL;
    localparam int unsigned COL_W = TGC_COL_W;
    localparam int unsigned NPOS  = TGC_NPOS;

    logic [NPOS-1:0]       therm_q;
    logic [NPOS-1:0]       clean;
    col_res_t [NCOL-1:0]   col_d;
    col_res_t [NCOL-1:0]   col_q;
    logic                  ovr_q;
    code_t                 level;

    // Stage 1: capture on the rising edge
    always_ff @(posedge clk) begin
        if (rst) therm_q <= '0;
        else     therm_q <= therm_in;
    end

    tgc_bubble_filter #(.N(NPOS)) u_filter (
        .raw   (therm_q),
        .clean (clean)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic below_c;
        if (c == 0) begin : g_first
            assign below_c = 1'b1;
        end else begin : g_rest
            assign below_c = clean[c*COL_W-1];
        end
        tgc_column_dec #(.COL_W(COL_W)) u_col (
            .seg   (clean[c*COL_W +: COL_W]),
            .below (below_c),
            .res   (col_d[c])
        );
    end

    // Stage 2: column latches on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            col_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            col_q <= col_d;
            ovr_q <= clean[NPOS-1];
        end
    end

    tgc_msb_enc #(.NCOL(NCOL)) u_msb (
        .cols  (col_q),
        .ovr   (ovr_q),
        .level (level)
    );

    // Stage 3: Gray output on the next rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            gray_out <= '0;
            ovr_out  <= 1'b0;
        end else begin
            gray_out <= bin_to_gray(level);
            ovr_out  <= ovr_q;
        end
    end

    // Latched column transition must sit on a real 1-to-0 step of the filtered vector
    logic [NPOS:0]     clean_ext;
    logic [NCOL-1:0]   edge_ok;
    assign clean_ext = {clean, 1'b1};

    always_comb begin
        for (int c = 0; c < NCOL; c++) begin
            edge_ok[c] = clean_ext[c*COL_W + int'(col_q[c].idx)]
                       & ~clean_ext[c*COL_W + int'(col_q[c].idx) + 1];
        end
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_chk
        AST_COL_EDGE: assert property (@(posedge clk) disable iff (rst)
            col_q[c].hit |-> edge_ok[c]);  // R8
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gray_out == '0 && !ovr_out));  // R7

    AST_OVR_FULL_CODE: assert property (@(posedge clk) disable iff (rst)
        ovr_out |-> (gray_out == bin_to_gray('1)));  // R3

    AST_ALL_ONES_LAT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && (&$past(therm_in, 2))) |-> ovr_out);  // R1

    AST_ALL_ZERO_LAT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ($past(therm_in, 2) == '0))
        |-> (gray_out == '0 && !ovr_out));  // R2

endmodule

// File: tb/thermo_gray_enc_tb.sv
`timescale 1ns/1ps
module thermo_gray_enc_tb;
    import tgc_pkg::*;

    localparam int NPOS = TGC_NPOS;
    localparam int CW   = TGC_CODE_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NPOS-1:0] therm_in = '0;
    logic [CW-1:0]   gray_out;
    logic            ovr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    thermo_gray_enc u_dut (
        .clk      (clk),
        .rst      (rst),
        .therm_in (therm_in),
        .gray_out (gray_out),
        .ovr_out  (ovr_out)
    );

    function automatic logic [NPOS-1:0] thermo(input int l);
        logic [NPOS-1:0] t;
        for (int i = 0; i < NPOS; i++) t[i] = (i < l);
        return t;
    endfunction

    function automatic logic [CW-1:0] gray_of(input int l);
        logic [CW-1:0] v;
        v = CW'(l);
        return v ^ (v >> 1);
    endfunction

    function automatic int ungray(input logic [CW-1:0] g);
        logic [CW-1:0] b;
        b[CW-1] = g[CW-1];
        for (int i = CW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return int'(b);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check_exact(input string req, input int lvl);
        logic [CW-1:0] eg;
        logic          eo;
        eo = (lvl >= NPOS);
        eg = eo ? gray_of(NPOS-1) : gray_of(lvl);
        checks++;
        if (gray_out !== eg || ovr_out !== eo) begin
            fails++;
            $display("FAIL %s level %0d: got gray=%b ovr=%b, expected gray=%b ovr=%b",
                     req, lvl, gray_out, ovr_out, eg, eo);
        end
    endtask

    task automatic check_near(input string req, input int lvl, input int pos, input bit exact);
        int got;
        int diff;
        got  = ovr_out ? NPOS : ungray(gray_out);
        diff = (got > lvl) ? got - lvl : lvl - got;
        checks++;
        if (exact ? (diff != 0) : (diff > 1)) begin
            fails++;
            $display("FAIL %s level %0d bubble at %0d: got %0d, expected %0d (tolerance %0d)",
                     req, lvl, pos, got, lvl, exact ? 0 : 1);
        end
    endtask

    task automatic one_sample(input logic [NPOS-1:0] pat);
        @(posedge clk); #2 therm_in = pat;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bubble_case(input string req, input int lvl, input int pos);
        bit ex;
        one_sample(thermo(lvl) ^ (NPOS'(1) << pos));
        ex = (pos + 3 <= lvl) || (pos >= lvl + 2);
        check_near(ex ? "R6" : req, lvl, pos, ex);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got hang, expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int exp_l [0:19];
        void'($urandom(32'd2024));

        // R7: reset state with a busy input
        therm_in = thermo(200);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_exact("R7", 0);
        @(posedge clk); #2 rst = 1'b0;

        // R2, R3: full sweep of clean levels
        for (int l = 0; l <= NPOS; l++) begin
            one_sample(thermo(l));
            check_exact(l == NPOS ? "R3" : "R2", l);
        end

        // R4: fixed code points
        one_sample(thermo(0));   check_exact("R4", 0);
        one_sample(thermo(127)); check_exact("R4", 127);
        one_sample(thermo(128)); check_exact("R4", 128);
        one_sample(thermo(255)); check_exact("R4", 255);

        // R8: column boundaries
        for (int c = 1; c < TGC_NCOL; c++) begin
            for (int d = -1; d <= 1; d++) begin
                one_sample(thermo(c * TGC_COL_W + d));
                check_exact("R8", c * TGC_COL_W + d);
            end
        end

        // R5: bubbles near the top, where overrange and correction meet
        for (int l = NPOS-3; l <= NPOS; l++) begin
            for (int p = NPOS-4; p < NPOS; p++) begin
                bubble_case("R5", l, p);
            end
        end
        // R5: bubbles near the bottom
        for (int l = 0; l <= 3; l++) begin
            for (int p = 0; p < 4; p++) begin
                bubble_case("R5", l, p);
            end
        end

        // R5, R6: random single bubbles
        for (int k = 0; k < 2500; k++) begin
            int l;
            int p;
            l = int'($urandom_range(0, NPOS));
            p = int'($urandom_range(0, NPOS-1));
            bubble_case("R5", l, p);
        end

        // R1: back-to-back samples, results one clock after capture
        for (int n = 0; n < 22; n++) begin
            @(posedge clk);
            if (n < 20) begin
                exp_l[n] = int'($urandom_range(0, NPOS));
                #2 therm_in = thermo(exp_l[n]);
            end
            @(negedge clk);
            if (n >= 2) check_exact("R1", exp_l[n-2]);
        end

        // R7: reset in mid-run with a full-scale input
        one_sample(thermo(NPOS));
        check_exact("R3", NPOS);
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_exact("R7", 0);
        @(posedge clk);
        @(negedge clk);
        check_exact("R7", 0);
        #2 rst = 1'b0;
        one_sample(thermo(77));
        check_exact("R2", 77);

        done = 1;
        summary();
        $finish;
    end

endmodule